// File: doc/BRIEF.md
# Paged Long Address Translator

This block turns a 16-bit long data address into a 24-bit physical address. The two top address bits pick one of four page pointer registers. The low 10 bits of the chosen pointer are placed above the 14-bit page offset. After reset the pointers map every long address onto the same physical address. Software-visible pointer updates arrive through a simple write port.

An override can be armed to change translation for the next one to four retired instructions. Page mode replaces the selected pointer with a supplied page number and keeps the offset. Segment mode places the whole 16-bit long address below an 8-bit segment number. A word access to an odd byte address is not translated. It raises a trap instead.

Results are registered and appear one clock after the request.

Top module: `long_addr_xlate`

## Requirements
- R1: While and after a synchronous reset (`rst` high), `phys_valid` and `trap` read 0 and pointer n holds n. Before any pointer write, a translated address therefore equals `{8'h00, req_addr}`.
- R2: With no override active, a request in cycle t gives `phys_valid`=1 and `phys_addr = {ptr[req_addr[15:14]][9:0], req_addr[13:0]}` in cycle t+1.
- R3: A pointer write (`pp_we`, `pp_sel`, `pp_wdata`) is used by requests in later cycles. A request in the same cycle as a write to the same pointer uses the old value.
- R4: Page override (`ovr_seg_mode`=0) translates to `{ovr_value[9:0], req_addr[13:0]}`, whatever the pointer selected by bits 15:14.
- R5: Segment override (`ovr_seg_mode`=1) translates to `{ovr_value[7:0], req_addr[15:0]}`.
- R6: An `ovr_start` pulse with range field r (0..3) arms the override from the next cycle. The override stays active until r+1 `retire` strobes have been seen, then normal paged mapping resumes.
- R7: A `retire` strobe in the same cycle as `ovr_start` is not counted. A `retire` strobe while no override is active has no effect.
- R8: A word request (`req_word`=1) with `req_addr[0]`=1 gives `trap`=1, `phys_valid`=0 and `phys_addr`=0 in the next cycle. An odd byte request is translated normally.
- R9: A cycle without `req_valid` gives `phys_valid`=0, `trap`=0 and `phys_addr`=0 in the next cycle.
- R10: An `ovr_start` while an override is active restarts it with the new mode, value and range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request this cycle |
| req_addr | input | 16 | Long data address |
| req_word | input | 1 | 1 = word access, 0 = byte access |
| pp_we | input | 1 | Page pointer write enable |
| pp_sel | input | 2 | Page pointer index to write |
| pp_wdata | input | 10 | New page pointer value |
| ovr_start | input | 1 | Arm an override |
| ovr_seg_mode | input | 1 | 0 = page override, 1 = segment override |
| ovr_value | input | 10 | Override page (10 bits) or segment (low 8 bits) |
| ovr_range | input | 2 | Override length minus one, in instructions |
| retire | input | 1 | One instruction retired |
| phys_valid | output | 1 | Registered translated address is valid |
| phys_addr | output | 24 | Registered physical address |
| trap | output | 1 | Registered misaligned word access trap |

## Verification
Two functions can land in the same cycle: a pointer write and a translation that reads that same pointer. The second collision is an override start arriving together with a retire strobe. The bench drives a write and a request to the same index in one cycle and expects the old pointer value. The next request must show the new value. It also starts overrides together with a retire strobe and counts the following retires against a bench model, to judge where normal mapping returns.

// File: rtl/xlate_pkg.sv
package xlate_pkg;
  typedef enum logic {
    OVR_PAGE = 1'b0,
    OVR_SEG  = 1'b1
  } ovr_mode_e;
endpackage

// File: rtl/page_ptr_bank.sv
module page_ptr_bank #(
  parameter int NPTR   = 4,
  parameter int PAGE_W = 10,
  localparam int SEL_W = $clog2(NPTR)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [SEL_W-1:0]  wsel,
  input  logic [PAGE_W-1:0] wdata,
  input  logic [SEL_W-1:0]  rsel,
  output logic [PAGE_W-1:0] rdata
);
  logic [PAGE_W-1:0] ptr [NPTR];

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    always_ff @(posedge clk) begin
      if (rst)
        ptr[i] <= PAGE_W'(i);
      else if (we && wsel == SEL_W'(i))
        ptr[i] <= wdata;
    end

    // R1: identity values right after reset
    assert_reset_identity_R1: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && !$past(we)) |-> ptr[i] == PAGE_W'(i));
    // R3: a write lands in the addressed pointer only
    assert_write_lands_R3: assert property (@(posedge clk) disable iff (rst)
      ($past(we) && $past(wsel) == SEL_W'(i) && !$past(rst)) |-> ptr[i] == $past(wdata));
  end

  assign rdata = ptr[rsel];
endmodule

// File: rtl/ovr_ctl.sv
module ovr_ctl
  import xlate_pkg::*;
#(
  parameter int RANGE_W = 2,
  parameter int VAL_W   = 10,
  localparam int CNT_W  = RANGE_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               seg_mode,
  input  logic [VAL_W-1:0]   value,
  input  logic [RANGE_W-1:0] range,
  input  logic               retire,
  output logic               active,
  output ovr_mode_e          mode,
  output logic [VAL_W-1:0]   val
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      mode <= OVR_PAGE;
      val  <= '0;
    end else if (start) begin
      cnt  <= CNT_W'(range) + CNT_W'(1);
      mode <= seg_mode ? OVR_SEG : OVR_PAGE;
      val  <= value;
    end else if (retire && cnt != '0) begin
      cnt <= cnt - CNT_W'(1);
    end
  end

  assign active = (cnt != '0);

  // R6 / R10: a start loads range+1, even over an active override
  assert_start_loads_R6: assert property (@(posedge clk) disable iff (rst)
    start |=> (active && cnt == CNT_W'($past(range)) + CNT_W'(1)));
  // R7: a retire alone counts down by one
  assert_retire_counts_R7: assert property (@(posedge clk) disable iff (rst)
    (!start && retire && active) |=> cnt == $past(cnt) - CNT_W'(1));
  // R7: without start or retire the count holds
  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!start && !retire) |=> $stable(cnt));
endmodule

// File: rtl/addr_compose.sv
module addr_compose
  import xlate_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 14,
  parameter int PAGE_W = 10,
  parameter int SEG_W  = 8,
  localparam int PHYS_W = PAGE_W + OFS_W
) (
  input  logic              word,
  input  logic [ADDR_W-1:0] addr,
  input  logic [PAGE_W-1:0] ptr_val,
  input  logic              ovr_active,
  input  ovr_mode_e         ovr_mode,
  input  logic [PAGE_W-1:0] ovr_val,
  output logic [PHYS_W-1:0] phys,
  output logic              misaligned
);
  logic [OFS_W-1:0] ofs;

  assign ofs        = addr[OFS_W-1:0];
  assign misaligned = word && addr[0];

  always_comb begin
    if (misaligned)
      phys = '0;
    else if (ovr_active && ovr_mode == OVR_SEG)
      phys = {ovr_val[SEG_W-1:0], addr};
    else if (ovr_active)
      phys = {ovr_val, ofs};
    else
      phys = {ptr_val, ofs};
  end

  initial begin
    assert_width_fit_R5: assert (SEG_W + ADDR_W == PHYS_W)
      else $error("segment and address widths must fill the physical width");
  end
endmodule

// File: rtl/long_addr_xlate.sv
module long_addr_xlate
  import xlate_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int OFS_W   = 14,
  parameter int PAGE_W  = 10,
  parameter int SEG_W   = 8,
  parameter int NPTR    = 4,
  parameter int RANGE_W = 2,
  localparam int SEL_W  = $clog2(NPTR),
  localparam int PHYS_W = PAGE_W + OFS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_word,
  input  logic               pp_we,
  input  logic [SEL_W-1:0]   pp_sel,
  input  logic [PAGE_W-1:0]  pp_wdata,
  input  logic               ovr_start,
  input  logic               ovr_seg_mode,
  input  logic [PAGE_W-1:0]  ovr_value,
  input  logic [RANGE_W-1:0] ovr_range,
  input  logic               retire,
  output logic               phys_valid,
  output logic [PHYS_W-1:0]  phys_addr,
  output logic               trap
);
  logic [PAGE_W-1:0] ptr_val;
  logic              ovr_active;
  ovr_mode_e         ovr_mode;
  logic [PAGE_W-1:0] ovr_val;
  logic [PHYS_W-1:0] phys_c;
  logic              misaligned;

  page_ptr_bank #(.NPTR(NPTR), .PAGE_W(PAGE_W)) u_ptrs (
    .clk  (clk),
    .rst  (rst),
    .we   (pp_we),
    .wsel (pp_sel),
    .wdata(pp_wdata),
    .rsel (req_addr[ADDR_W-1:OFS_W]),
    .rdata(ptr_val)
  );

  ovr_ctl #(.RANGE_W(RANGE_W), .VAL_W(PAGE_W)) u_ovr (
    .clk     (clk),
    .rst     (rst),
    .start   (ovr_start),
    .seg_mode(ovr_seg_mode),
    .value   (ovr_value),
    .range   (ovr_range),
    .retire  (retire),
    .active  (ovr_active),
    .mode    (ovr_mode),
    .val     (ovr_val)
  );

  addr_compose #(.ADDR_W(ADDR_W), .OFS_W(OFS_W), .PAGE_W(PAGE_W), .SEG_W(SEG_W)) u_comp (
    .word      (req_word),
    .addr      (req_addr),
    .ptr_val   (ptr_val),
    .ovr_active(ovr_active),
    .ovr_mode  (ovr_mode),
    .ovr_val   (ovr_val),
    .phys      (phys_c),
    .misaligned(misaligned)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      phys_valid <= 1'b0;
      phys_addr  <= '0;
      trap       <= 1'b0;
    end else begin
      phys_valid <= req_valid && !misaligned;
      trap       <= req_valid && misaligned;
      phys_addr  <= req_valid ? phys_c : '0;
    end
  end

  // R8: a trap never comes with a valid address
  assert_trap_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    trap |-> (!phys_valid && phys_addr == '0));
  // R8: odd word request traps one cycle later
  assert_odd_word_traps_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_word && req_addr[0]) |=> trap);
  // R9: no request gives a quiet output
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!phys_valid && !trap && phys_addr == '0));
  // R2: an aligned request is answered next cycle
  assert_answer_next_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !(req_word && req_addr[0])) |=> phys_valid);
  // R2: offset bits pass through in every mapping
  assert_offset_kept_R2: assert property (@(posedge clk) disable iff (rst)
    phys_valid |-> phys_addr[OFS_W-1:0] == $past(req_addr[OFS_W-1:0]));
endmodule

// File: tb/long_addr_xlate_bench.sv
module long_addr_xlate_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_word, pp_we, ovr_start, ovr_seg_mode, retire;
  logic [15:0] req_addr;
  logic [1:0]  pp_sel, ovr_range;
  logic [9:0]  pp_wdata, ovr_value;
  logic        phys_valid, trap;
  logic [23:0] phys_addr;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;

  logic [9:0] mp [4];
  int         m_cnt;
  bit         m_seg;
  logic [9:0] m_val;

  always #2 clk = ~clk;

  long_addr_xlate u_long_addr_xlate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_word(req_word), .pp_we(pp_we), .pp_sel(pp_sel), .pp_wdata(pp_wdata),
    .ovr_start(ovr_start), .ovr_seg_mode(ovr_seg_mode), .ovr_value(ovr_value),
    .ovr_range(ovr_range), .retire(retire), .phys_valid(phys_valid),
    .phys_addr(phys_addr), .trap(trap)
  );

  task automatic summary();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
      summary();
    end
  end

  task automatic check(string tag, logic ev, logic [23:0] ea, logic et);
    checks++;
    if (phys_valid !== ev || phys_addr !== ea || trap !== et) begin
      fails++;
      $display("FAIL %s: actual valid=%b addr=%h trap=%b, expected valid=%b addr=%h trap=%b",
               tag, phys_valid, phys_addr, trap, ev, ea, et);
    end
  endtask

  // one cycle: drive at negedge, model, check at next negedge
  task automatic step(string tag, logic rv, logic [15:0] a, logic w,
                      logic we, logic [1:0] sel, logic [9:0] wd,
                      logic os, logic osm, logic [9:0] ov, logic [1:0] orng,
                      logic ret);
    logic        ev, et;
    logic [23:0] ea;
    req_valid = rv; req_addr = a; req_word = w;
    pp_we = we; pp_sel = sel; pp_wdata = wd;
    ovr_start = os; ovr_seg_mode = osm; ovr_value = ov; ovr_range = orng;
    retire = ret;
    ev = 1'b0; et = 1'b0; ea = 24'h0;
    if (rv) begin
      if (w && a[0]) et = 1'b1;
      else begin
        ev = 1'b1;
        if (m_cnt > 0 && m_seg) ea = {m_val[7:0], a};
        else if (m_cnt > 0)     ea = {m_val, a[13:0]};
        else                    ea = {mp[a[15:14]], a[13:0]};
      end
    end
    if (we) mp[sel] = wd;
    if (os) begin m_cnt = int'(orng) + 1; m_seg = osm; m_val = ov; end
    else if (ret && m_cnt > 0) m_cnt--;
    @(negedge clk);
    check(tag, ev, ea, et);
  endtask

  task automatic req(string tag, logic [15:0] a, logic w, logic ret);
    step(tag, 1'b1, a, w, 1'b0, 2'd0, 10'd0, 1'b0, 1'b0, 10'd0, 2'd0, ret);
  endtask

  task automatic sweep(string tag);
    logic [13:0] ofs [6] = '{14'h0000, 14'h0001, 14'h0002, 14'h3FFE, 14'h3FFF, 14'h1235};
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 6; k++)
        for (int w = 0; w < 2; w++)
          req(tag, {2'(s), ofs[k]}, 1'(w), 1'b0);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) mp[i] = 10'(i);
    m_cnt = 0; m_seg = 1'b0; m_val = '0;
    rst = 1'b1;
    req_valid = 0; req_addr = 0; req_word = 0; pp_we = 0; pp_sel = 0; pp_wdata = 0;
    ovr_start = 0; ovr_seg_mode = 0; ovr_value = 0; ovr_range = 0; retire = 0;
    repeat (3) @(negedge clk);
    check("R1 reset outputs", 1'b0, 24'h0, 1'b0);
    rst = 1'b0;

    // R1 identity map, R8 odd-word traps, R2 paged mapping
    sweep("R1 identity map / R8 alignment");
    // R9 idle cycle
    step("R9 idle", 1'b0, 16'hFFFF, 1'b1, 0, 0, 0, 0, 0, 0, 0, 0);
    // R7 retire with nothing active has no effect
    req("R7 stray retire", 16'h4002, 1'b0, 1'b1);
    req("R7 stray retire after", 16'h8004, 1'b1, 1'b0);

    // R3 rewrite all pointers, then sweep
    for (int i = 0; i < 4; i++)
      step("R3 write", 1'b0, 0, 0, 1'b1, 2'(i), 10'h2A5 ^ 10'(i * 77), 0, 0, 0, 0, 0);
    sweep("R2 paged map");

    // R3 write and read same pointer in one cycle
    for (int i = 0; i < 4; i++) begin
      step("R3 same-cycle old value", 1'b1, {2'(i), 14'h0ABC}, 1'b1,
           1'b1, 2'(i), 10'h3C0 + 10'(i), 0, 0, 0, 0, 0);
      req("R3 new value next", {2'(i), 14'h0ABC}, 1'b1, 1'b0);
    end

    // R4 R5 R6 R7: every mode and range, start with and without retire
    for (int md = 0; md < 2; md++)
      for (int r = 0; r < 4; r++)
        for (int sr = 0; sr < 2; sr++) begin
          step(md ? "R5 seg start" : "R4 page start", 1'b1, 16'hC010, 1'b0,
               0, 0, 0, 1'b1, 1'(md), 10'h1F0 + 10'(r * 3), 2'(r), 1'(sr));
          for (int k = 0; k < r + 3; k++)
            req(md ? "R5/R6 seg window" : "R4/R6 page window",
                16'h4000 + 16'(k * 4 + 3 * 16384 * (k % 2)), 1'(k % 2), 1'b1);
          req("R6 back to paged", 16'h8000, 1'b0, 1'b0);
        end

    // R10 restart while active
    step("R10 first start", 1'b0, 0, 0, 0, 0, 0, 1'b1, 1'b0, 10'h155, 2'd3, 0);
    req("R10 first active", 16'h2222, 1'b0, 1'b1);
    step("R10 restart", 1'b1, 16'h3334, 1'b1, 0, 0, 0, 1'b1, 1'b1, 10'h0E7, 2'd0, 0);
    req("R10 new segment", 16'hBEEF, 1'b0, 1'b1);
    req("R10 expired", 16'hBEEE, 1'b1, 1'b0);
    req("R8 odd word under idle", 16'hFFFF, 1'b1, 1'b0);

    done = 1'b1;
    summary();
  end
endmodule